// File: doc/BRIEF.md
# Power Mode Sequencer with Override Watchdog

This block moves a battery-monitor device down through its power modes whenever no current is measured. It starts in full operation (NORMAL), steps to IDLE, then to DOZE and finally to SLEEP. Each step waits for a programmable number of time-base ticks. Seeing current in IDLE or DOZE sends the device straight back to NORMAL. A separate wake input, raised when a load or charger is connected, is the only way out of SLEEP.

The same block also supervises sessions in which a host microcontroller overrides internal operation. While the override is active, a watchdog counts ticks, and every valid byte received by the serial slave reloads it. If the count runs out, the block forces all power FETs off and raises a timeout flag. The FETs stay off until a valid command arrives.

No data flows through this block, so there is no valid/ready interface. Every pin is a plain level or a single-cycle strobe, sampled on the rising clock edge. The reset is asynchronous and active low.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, `mode` reads 0 (NORMAL), and `fets_off` and `wd_expired` are both low. Mode codes are NORMAL=0, IDLE=1, DOZE=2, SLEEP=3.
- R2: In NORMAL, the block moves to IDLE on the `idle_time`-th tick seen with `cur_seen` low. A cycle with `cur_seen` high restarts that count. A setting of 0 acts like 1.
- R3: In IDLE, the block moves to DOZE on the `doze_time`-th tick.
- R4: In DOZE, the block moves to SLEEP on the `sleep_time`-th tick.
- R5: `cur_seen` high in IDLE or DOZE returns `mode` to NORMAL on the next cycle. It wins over a tick in the same cycle.
- R6: SLEEP is left only when `wake` is high, and then the block goes to NORMAL. `cur_seen` and `tick` have no effect in SLEEP.
- R7: The tick count restarts on every mode entry. `mode` never changes in a cycle that has no tick, no current and no wake.
- R8: While `ovr_active` is high, the watchdog expires on the `WD_TICKS`-th tick that arrives without `byte_ok`. `fets_off` and `wd_expired` go high on the next cycle.
- R9: `byte_ok` reloads the watchdog to zero and wins over a tick in the same cycle.
- R10: `fets_off` stays high until a `cmd_ok` strobe. `cmd_ok` clears `fets_off` and `wd_expired` and reloads the watchdog.
- R11: While `ovr_active` is low, the watchdog holds at zero, `wd_expired` clears on the next cycle, and `fets_off` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time-base strobe |
| cur_seen | input | 1 | Current measured this cycle |
| wake | input | 1 | Load or charger connected |
| idle_time | input | TW | Ticks spent in NORMAL before IDLE |
| doze_time | input | TW | Ticks spent in IDLE before DOZE |
| sleep_time | input | TW | Ticks spent in DOZE before SLEEP |
| ovr_active | input | 1 | Host override of internal operation is set |
| byte_ok | input | 1 | Strobe: valid byte received by the serial slave |
| cmd_ok | input | 1 | Strobe: valid command received |
| mode | output | 2 | Current power mode (0..3) |
| fets_off | output | 1 | Force all power FETs off |
| wd_expired | output | 1 | Override watchdog has timed out |

## Verification
Some rules are checked by assertions on every cycle:
- SLEEP holds without `wake`, and `wake` leads to NORMAL.
- Current snaps IDLE and DOZE back to NORMAL.
- A tickless cycle never changes the mode, and the mode moves down at most one step at a time.
- `fets_off` stays latched until `cmd_ok`, and `cmd_ok` clears both watchdog outputs.
- The timeout flag drops once the override ends.
- A `byte_ok` always prevents a trip in the following cycle.

Other behaviour only the bench scenarios can show: the exact tick on which each mode step or watchdog expiry lands, the restart of the count after current or after an entry, and the zero-setting case. These are checked against a cycle-by-cycle reference model, under both directed and random stimulus.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [1:0] {
    PM_NORMAL = 2'd0,
    PM_IDLE   = 2'd1,
    PM_DOZE   = 2'd2,
    PM_SLEEP  = 2'd3
  } pmode_t;
endpackage

// File: rtl/pms_tick_count.sv
// Counts time-base ticks up to a limit. done pulses on the tick that reaches it.
module pms_tick_count #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;
  logic         reach;

  // A limit of 0 is reached on the first tick, just as a limit of 1 is.
  assign reach = ({1'b0, cnt} + {{W{1'b0}}, 1'b1}) >= {1'b0, limit};
  assign done  = tick & ~clr & reach;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= reach ? '0 : cnt + W'(1);
    end
  end
endmodule

// File: rtl/pms_mode_fsm.sv
// Steps down through the power modes while no current is measured.
module pms_mode_fsm
  import pms_pkg::*;
#(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cur_seen,
  input  logic          wake,
  input  logic [TW-1:0] idle_time,
  input  logic [TW-1:0] doze_time,
  input  logic [TW-1:0] sleep_time,
  output pmode_t        mode_q
);
  pmode_t        mode_d;
  logic          clr;
  logic          done;
  logic [TW-1:0] lim;

  always_comb begin
    mode_d = mode_q;
    clr    = 1'b0;
    lim    = idle_time;
    unique case (mode_q)
      PM_NORMAL: begin
        lim = idle_time;
        clr = cur_seen;
        if (done) mode_d = PM_IDLE;
      end
      PM_IDLE: begin
        lim = doze_time;
        clr = cur_seen;
        if (cur_seen)  mode_d = PM_NORMAL;
        else if (done) mode_d = PM_DOZE;
      end
      PM_DOZE: begin
        lim = sleep_time;
        clr = cur_seen;
        if (cur_seen)  mode_d = PM_NORMAL;
        else if (done) mode_d = PM_SLEEP;
      end
      PM_SLEEP: begin
        clr = 1'b1;
        if (wake) mode_d = PM_NORMAL;
      end
      default: mode_d = PM_NORMAL;
    endcase
  end

  // The counter clears itself on done, so each entry starts from zero.
  pms_tick_count #(.W(TW)) u_dwell (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .tick  (tick),
    .limit (lim),
    .done  (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PM_NORMAL;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/pms_ovr_watchdog.sv
// Supervises host override sessions. Expiry latches the FETs off.
module pms_ovr_watchdog #(
  parameter int WD_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ovr_active,
  input  logic byte_ok,
  input  logic cmd_ok,
  output logic fets_off,
  output logic wd_expired
);
  localparam int WDW = $clog2(WD_TICKS + 1);

  logic clr;
  logic trip;

  // The count is held at zero while idle, on reload, and while tripped.
  assign clr = ~ovr_active | byte_ok | cmd_ok | fets_off;

  pms_tick_count #(.W(WDW)) u_wd (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .tick  (tick),
    .limit (WDW'(WD_TICKS)),
    .done  (trip)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fets_off   <= 1'b0;
      wd_expired <= 1'b0;
    end else begin
      if (cmd_ok)    fets_off <= 1'b0;
      else if (trip) fets_off <= 1'b1;

      if (cmd_ok || !ovr_active) wd_expired <= 1'b0;
      else if (trip)             wd_expired <= 1'b1;
    end
  end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int TW       = 10,
  parameter int WD_TICKS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cur_seen,
  input  logic          wake,
  input  logic [TW-1:0] idle_time,
  input  logic [TW-1:0] doze_time,
  input  logic [TW-1:0] sleep_time,
  input  logic          ovr_active,
  input  logic          byte_ok,
  input  logic          cmd_ok,
  output logic [1:0]    mode,
  output logic          fets_off,
  output logic          wd_expired
);
  pmode_t mode_q;

  pms_mode_fsm #(.TW(TW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cur_seen   (cur_seen),
    .wake       (wake),
    .idle_time  (idle_time),
    .doze_time  (doze_time),
    .sleep_time (sleep_time),
    .mode_q     (mode_q)
  );

  pms_ovr_watchdog #(.WD_TICKS(WD_TICKS)) u_wdog (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .ovr_active (ovr_active),
    .byte_ok    (byte_ok),
    .cmd_ok     (cmd_ok),
    .fets_off   (fets_off),
    .wd_expired (wd_expired)
  );

  assign mode = mode_q;
endmodule

// File: rtl/pms_checker.sv
module pms_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       cur_seen,
  input logic       wake,
  input logic       ovr_active,
  input logic       byte_ok,
  input logic       cmd_ok,
  input logic [1:0] mode,
  input logic       fets_off,
  input logic       wd_expired
);
  p_sleep_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !wake) |=> mode == 2'd3);

  p_wake_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && wake) |=> mode == 2'd0);

  p_snap_normal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_seen && (mode == 2'd1 || mode == 2'd2)) |=> mode == 2'd0);

  p_no_tick_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cur_seen && mode != 2'd3) |=> $stable(mode));

  p_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd3 && !cur_seen) |=>
      (mode == $past(mode) || mode == 2'($past(mode) + 2'd1)));

  p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_active |=> !wd_expired);

  p_no_trip_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_active && !fets_off) |=> !fets_off);

  p_flag_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expired |-> fets_off);

  p_off_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fets_off && !cmd_ok) |=> fets_off);

  p_cmd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ok |=> (!fets_off && !wd_expired));

  p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ok && !fets_off) |=> !fets_off);
endmodule

bind pwr_mode_seq pms_checker u_chk (.*);

// File: tb/pwr_mode_seq_test.sv
`timescale 1ns/1ps
module pwr_mode_seq_test;
  localparam int TW  = 10;
  localparam int WDT = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic tick = 0, cur_seen = 0, wake = 0, ovr_active = 0, byte_ok = 0, cmd_ok = 0;
  logic [TW-1:0] idle_time = 3, doze_time = 2, sleep_time = 4;
  logic [1:0] mode;
  logic fets_off, wd_expired;

  pwr_mode_seq #(.TW(TW), .WD_TICKS(WDT)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cur_seen(cur_seen), .wake(wake),
    .idle_time(idle_time), .doze_time(doze_time), .sleep_time(sleep_time),
    .ovr_active(ovr_active), .byte_ok(byte_ok), .cmd_ok(cmd_ok),
    .mode(mode), .fets_off(fets_off), .wd_expired(wd_expired)
  );

  int n_chk = 0, n_err = 0;
  // reference model state
  int m_mode = 0, m_cnt = 0, m_wc = 0, m_fets = 0, m_exp = 0;
  // values applied at the next cycle boundary
  int nx_ovr = 0, nx_idle = 3, nx_doze = 2, nx_sleep = 4;
  // outputs sampled at the start of the last cycle
  int s_mode, s_fets, s_exp;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int lim;
    if (m_mode == 3) begin
      m_cnt = 0;
      if (wake) m_mode = 0;
    end else if (cur_seen) begin
      m_mode = 0;
      m_cnt = 0;
    end else if (tick) begin
      lim = (m_mode == 0) ? int'(idle_time) : (m_mode == 1) ? int'(doze_time) : int'(sleep_time);
      if (m_cnt + 1 >= lim) begin
        m_mode = m_mode + 1;
        m_cnt = 0;
      end else m_cnt = m_cnt + 1;
    end
    begin
      bit trip = 0;
      if (!ovr_active || byte_ok || cmd_ok || m_fets != 0) m_wc = 0;
      else if (tick) begin
        if (m_wc + 1 >= WDT) begin trip = 1; m_wc = 0; end
        else m_wc = m_wc + 1;
      end
      if (cmd_ok) m_fets = 0; else if (trip) m_fets = 1;
      if (cmd_ok || !ovr_active) m_exp = 0; else if (trip) m_exp = 1;
    end
  endtask

  task automatic cyc(string tag, bit t, bit c = 0, bit w = 0, bit b = 0, bit k = 0);
    @(negedge clk);
    s_mode = int'(mode); s_fets = int'(fets_off); s_exp = int'(wd_expired);
    chk(tag, "mode", s_mode, m_mode);
    chk(tag, "fets_off", s_fets, m_fets);
    chk(tag, "wd_expired", s_exp, m_exp);
    tick = t; cur_seen = c; wake = w; byte_ok = b; cmd_ok = k;
    ovr_active = nx_ovr[0];
    idle_time = TW'(nx_idle); doze_time = TW'(nx_doze); sleep_time = TW'(nx_sleep);
    model_step();
  endtask

  task automatic ticks(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 1);
  endtask

  initial begin
    #1ms;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "mode", int'(mode), 0);
    chk("R1", "fets_off", int'(fets_off), 0);
    chk("R1", "wd_expired", int'(wd_expired), 0);
    rst_n = 1'b1;

    // R2, R3, R4: full descent with a tick every cycle
    ticks("R2", 3); cyc("R2", 0); chk("R2", "mode", s_mode, 1);
    ticks("R3", 2); cyc("R3", 0); chk("R3", "mode", s_mode, 2);
    ticks("R4", 4); cyc("R4", 0); chk("R4", "mode", s_mode, 3);

    // R6: current and ticks are ignored in SLEEP, wake exits
    cyc("R6", 1, 1); cyc("R6", 1, 1); cyc("R6", 0); chk("R6", "mode", s_mode, 3);
    cyc("R6", 0, 0, 1); cyc("R6", 0); chk("R6", "mode", s_mode, 0);

    // R2: current restarts the NORMAL count
    ticks("R2", 2); cyc("R2", 0, 1); ticks("R2", 2); cyc("R2", 0);
    chk("R2", "mode", s_mode, 0);
    cyc("R2", 1); cyc("R2", 0); chk("R2", "mode", s_mode, 1);

    // R5: current in IDLE
    cyc("R5", 0, 1); cyc("R5", 0); chk("R5", "mode", s_mode, 0);
    // R5: current with a tick in DOZE
    ticks("R5", 5); cyc("R5", 0); chk("R5", "mode", s_mode, 2);
    cyc("R5", 1, 1); cyc("R5", 0); chk("R5", "mode", s_mode, 0);

    // R2: a setting of 0 acts like 1
    nx_idle = 0; cyc("R2", 0); cyc("R2", 1); cyc("R2", 0);
    chk("R2", "mode", s_mode, 1);
    nx_idle = 3; cyc("R7", 0, 1);

    // R8: the watchdog expires on the WDT-th tick
    nx_ovr = 1;
    ticks("R8", WDT - 1); cyc("R8", 0); chk("R8", "fets_off", s_fets, 0);
    cyc("R8", 1); cyc("R8", 0);
    chk("R8", "fets_off", s_fets, 1); chk("R8", "wd_expired", s_exp, 1);

    // R10: latched until a command; a byte does not clear it
    ticks("R10", 20); cyc("R10", 0, 0, 0, 1); cyc("R10", 0);
    chk("R10", "fets_off", s_fets, 1);
    cyc("R10", 0, 0, 0, 0, 1); cyc("R10", 0);
    chk("R10", "fets_off", s_fets, 0); chk("R10", "wd_expired", s_exp, 0);

    // R9: a byte reloads the count, even with a tick in the same cycle
    ticks("R9", WDT - 1); cyc("R9", 1, 0, 0, 1); ticks("R9", WDT - 1); cyc("R9", 0);
    chk("R9", "fets_off", s_fets, 0);
    cyc("R9", 1); cyc("R9", 0); chk("R9", "fets_off", s_fets, 1);

    // R11: the override ends; the flag clears and the FETs stay off
    nx_ovr = 0; cyc("R11", 0); cyc("R11", 0);
    chk("R11", "wd_expired", s_exp, 0); chk("R11", "fets_off", s_fets, 1);
    cyc("R11", 0, 0, 0, 0, 1); ticks("R11", 3 * WDT); cyc("R11", 0);
    chk("R11", "fets_off", s_fets, 0);

    // R7: random mix against the model
    for (int i = 0; i < 4000; i++) begin
      if (i % 97 == 0) begin
        nx_idle = $urandom_range(0, 5); nx_doze = $urandom_range(0, 5);
        nx_sleep = $urandom_range(0, 5); nx_ovr = $urandom_range(0, 3) != 0;
      end
      cyc("R7", $urandom_range(0, 1) == 1, $urandom_range(0, 15) == 0,
          $urandom_range(0, 7) == 0, $urandom_range(0, 11) == 0,
          $urandom_range(0, 40) == 0);
    end
    cyc("R7", 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule